// File: doc/BRIEF.md
# Deferred Invalidation Queue with Load Barrier

Each core has one of these queues. It receives line-invalidation requests from other cores. A request is accepted and acknowledged in the cycle it arrives, while the queue has room. The matching tag in the local cache is cleared later: the queue drives the oldest pending line address onto a tag-invalidate port, and pops it in each cycle that the cache tag logic accepts it. Because of this, the requesting core sees its acknowledge before the local copy is actually gone.

A one-cycle barrier pulse tags every entry that is pending at that moment. From then on, the load-issue handshake refuses loads until every tagged entry has been written into the tags. A load therefore cannot hit a line whose invalidation was accepted before the barrier. Entries that arrive after the pulse are untagged and do not hold loads back. Two further checks apply even without a barrier. A load whose address matches any pending entry is flagged as a forced miss, so it refetches the line. An outgoing coherence message about a line is withheld until no pending entry names that line.

Top module: `invq_top`

## Requirements
- R1: `inv_ack` is high in every cycle in which fewer than 8 entries are held. A request with `inv_valid` and `inv_ack` both high is stored at that clock edge.
- R2: With 8 entries held, `inv_ack` is low and no request is stored. In the cycle after an entry leaves a full queue, `inv_ack` is high again.
- R3: `tag_inv_valid` is high whenever the queue is not empty, and `tag_inv_addr` shows the oldest entry. Each edge with `tag_ready` high removes exactly that one entry, so lines are applied in arrival order.
- R4: A `rbar` pulse tags every entry held in that cycle. `ld_ready` stays low until all tagged entries have been removed.
- R5: A load presented in the same cycle as a `rbar` pulse is held whenever the queue is not empty. A pulse on an empty queue does not lower `ld_ready`.
- R6: Entries accepted in or after the barrier cycle are untagged. `ld_ready` rises once the last tagged entry is gone, even if later entries remain.
- R7: `ld_force_miss` is high while `ld_valid` is high and `ld_addr` equals any held entry, whether or not a barrier is pending.
- R8: `msg_grant` is low while `msg_valid` is high and `msg_addr` matches a held entry. Otherwise it follows `msg_valid`.
- R9: After reset the queue is empty: `tag_inv_valid` is low, and `inv_ack` and `ld_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_valid | input | 1 | Incoming invalidation request |
| inv_addr | input | AW | Line address of the request |
| inv_ack | output | 1 | Request accepted (space available) |
| rbar | input | 1 | Read-barrier pulse |
| ld_valid | input | 1 | Load issue request |
| ld_addr | input | AW | Load line address |
| ld_ready | output | 1 | Load may issue this cycle |
| ld_force_miss | output | 1 | Load address has a pending invalidation |
| msg_valid | input | 1 | Core wants to send a coherence message |
| msg_addr | input | AW | Line address of that message |
| msg_grant | output | 1 | Message may be sent |
| tag_inv_valid | output | 1 | Oldest pending invalidation presented |
| tag_inv_addr | output | AW | Line address to invalidate in the tags |
| tag_ready | input | 1 | Tag port free; entry applied at the edge |

## Verification
The bench fills the queue, raises a barrier while a load waits in the same cycle, and then adds a request after the barrier. It checks that `ld_ready` rises exactly when the third tagged entry drains and not one entry earlier. A design that failed to tag entries would let the load see a stale line. A design that tagged late arrivals would hold loads one cycle too long. The bench also fills all 8 slots to confirm that the ninth request waits without being lost. It checks that forced misses and withheld messages follow the pending addresses, and a scoreboard catches any drain order other than arrival order.

// File: rtl/invq_pkg.sv
package invq_pkg;
  parameter int INVQ_DEPTH_DFLT = 8;
  parameter int INVQ_AW_DFLT    = 32;

  // circular pointer step for any depth
  function automatic int unsigned invq_step(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/invq_store.sv
module invq_store #(
  parameter int DEPTH = invq_pkg::INVQ_DEPTH_DFLT,
  parameter int AW    = invq_pkg::INVQ_AW_DFLT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic          pop,
  input  logic          barrier,
  input  logic [AW-1:0] ld_addr,
  input  logic [AW-1:0] msg_addr,
  output logic [AW-1:0] head_addr,
  output logic          full,
  output logic          empty,
  output logic          marked_any,
  output logic          ld_hit,
  output logic          msg_hit
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [PW-1:0] head_q, head_d, tail_q, tail_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DEPTH-1:0] vld_q, vld_d, mrk_q, mrk_d;
  logic [DEPTH-1:0] ld_m, msg_m;
  logic [AW-1:0] slot_q [DEPTH];

  assign full       = (cnt_q == CW'(DEPTH));
  assign empty      = (cnt_q == '0);
  assign marked_any = |mrk_q;
  assign head_addr  = slot_q[head_q];
  assign ld_hit     = |ld_m;
  assign msg_hit    = |msg_m;

  always_comb begin
    head_d = pop  ? PW'(invq_pkg::invq_step(32'(head_q), DEPTH)) : head_q;
    tail_d = push ? PW'(invq_pkg::invq_step(32'(tail_q), DEPTH)) : tail_q;
    cnt_d  = cnt_q + CW'(push) - CW'(pop);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_comb begin
      vld_d[i] = vld_q[i];
      mrk_d[i] = mrk_q[i];
      if (barrier && vld_q[i]) mrk_d[i] = 1'b1;
      if (pop && head_q == PW'(i)) begin
        vld_d[i] = 1'b0;
        mrk_d[i] = 1'b0;
      end
      if (push && tail_q == PW'(i)) begin
        vld_d[i] = 1'b1;
        mrk_d[i] = 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (push && tail_q == PW'(i)) slot_q[i] <= push_addr;
    end

    assign ld_m[i]  = vld_q[i] && (slot_q[i] == ld_addr);
    assign msg_m[i] = vld_q[i] && (slot_q[i] == msg_addr);

    // R4: a tag never outlives its entry
    assert_mark_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mrk_q[i] |-> vld_q[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      vld_q  <= '0;
      mrk_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
      vld_q  <= vld_d;
      mrk_q  <= mrk_d;
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < CW'(DEPTH)));

  assert_barrier_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (barrier && empty && !push) |=> !marked_any);
endmodule

// File: rtl/invq_gate.sv
module invq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic full,
  input  logic empty,
  input  logic marked_any,
  input  logic barrier,
  input  logic ld_valid,
  input  logic ld_hit,
  input  logic msg_valid,
  input  logic msg_hit,
  input  logic tag_ready,
  input  logic inv_valid,
  output logic inv_ack,
  output logic push,
  output logic tag_valid,
  output logic pop,
  output logic ld_ready,
  output logic ld_force_miss,
  output logic msg_grant
);
  always_comb begin
    inv_ack       = !full;
    push          = inv_valid && !full;
    tag_valid     = !empty;
    pop           = !empty && tag_ready;
    ld_ready      = !marked_any && !(barrier && !empty);
    ld_force_miss = ld_valid && ld_hit;
    msg_grant     = msg_valid && !msg_hit;
  end

  // R5: a barrier over a non-empty queue holds the load of the following cycle too
  assert_barrier_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (barrier && !empty && !pop) |=> !ld_ready);
endmodule

// File: rtl/invq_top.sv
module invq_top #(
  parameter int DEPTH = invq_pkg::INVQ_DEPTH_DFLT,
  parameter int AW    = invq_pkg::INVQ_AW_DFLT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inv_valid,
  input  logic [AW-1:0] inv_addr,
  output logic          inv_ack,
  input  logic          rbar,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_ready,
  output logic          ld_force_miss,
  input  logic          msg_valid,
  input  logic [AW-1:0] msg_addr,
  output logic          msg_grant,
  output logic          tag_inv_valid,
  output logic [AW-1:0] tag_inv_addr,
  input  logic          tag_ready
);
  logic full, empty, marked_any, ld_hit, msg_hit, push, pop;

  invq_store #(.DEPTH(DEPTH), .AW(AW)) store_i (
    .clk(clk), .rst_n(rst_n), .push(push), .push_addr(inv_addr), .pop(pop),
    .barrier(rbar), .ld_addr(ld_addr), .msg_addr(msg_addr),
    .head_addr(tag_inv_addr), .full(full), .empty(empty),
    .marked_any(marked_any), .ld_hit(ld_hit), .msg_hit(msg_hit)
  );

  invq_gate gate_i (
    .clk(clk), .rst_n(rst_n), .full(full), .empty(empty),
    .marked_any(marked_any), .barrier(rbar), .ld_valid(ld_valid),
    .ld_hit(ld_hit), .msg_valid(msg_valid), .msg_hit(msg_hit),
    .tag_ready(tag_ready), .inv_valid(inv_valid), .inv_ack(inv_ack),
    .push(push), .tag_valid(tag_inv_valid), .pop(pop), .ld_ready(ld_ready),
    .ld_force_miss(ld_force_miss), .msg_grant(msg_grant)
  );

  assert_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_inv_valid && !tag_ready) |=> (tag_inv_valid && $stable(tag_inv_addr)));

  assert_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && inv_ack) |=> tag_inv_valid);
endmodule

// File: tb/invq_top_tb_top.sv
module invq_top_tb_top;
  localparam int CLK_P = 10;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inv_valid = 1'b0, rbar = 1'b0, ld_valid = 1'b0, msg_valid = 1'b0, tag_ready = 1'b0;
  logic [AW-1:0] inv_addr = '0, ld_addr = '0, msg_addr = '0;
  logic inv_ack, ld_ready, ld_force_miss, msg_grant, tag_inv_valid;
  logic [AW-1:0] tag_inv_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [AW-1:0] exp_q [$];

  always #(CLK_P/2) clk = ~clk;

  invq_top #(.DEPTH(8), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .inv_valid(inv_valid), .inv_addr(inv_addr),
    .inv_ack(inv_ack), .rbar(rbar), .ld_valid(ld_valid), .ld_addr(ld_addr),
    .ld_ready(ld_ready), .ld_force_miss(ld_force_miss), .msg_valid(msg_valid),
    .msg_addr(msg_addr), .msg_grant(msg_grant), .tag_inv_valid(tag_inv_valid),
    .tag_inv_addr(tag_inv_addr), .tag_ready(tag_ready)
  );

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: just before each rising edge, score a tag write against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/2 - 1);
      if (rst_n && tag_inv_valid && tag_ready) begin
        if (exp_q.size() == 0) check("R3 unexpected apply", tag_inv_addr, '1);
        else check("R3 order", tag_inv_addr, exp_q.pop_front());
      end
    end
  end

  // driver: offer one request for one cycle; record it when accepted
  task automatic push_inv(input logic [AW-1:0] a);
    @(negedge clk);
    inv_valid = 1'b1;
    inv_addr  = a;
    #1;
    check("R1 ack with space", inv_ack, 1'b1);
    if (inv_ack) exp_q.push_back(a);
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 20000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R9 reset state
    check("R9 tag_inv_valid", tag_inv_valid, 1'b0);
    check("R9 inv_ack", inv_ack, 1'b1);
    check("R9 ld_ready", ld_ready, 1'b1);
    rst_n = 1'b1;

    // hold the tag port busy and queue three lines
    push_inv(32'h10);
    push_inv(32'h11);
    push_inv(32'h12);
    #1;
    check("R3 head shown", tag_inv_addr, 32'h10);
    ld_valid = 1'b1; ld_addr = 32'h11; #1;
    check("R7 hit forces miss", ld_force_miss, 1'b1);
    check("R7 no barrier no stall", ld_ready, 1'b1);
    ld_addr = 32'h99; #1;
    check("R7 other line no miss", ld_force_miss, 1'b0);
    msg_valid = 1'b1; msg_addr = 32'h12; #1;
    check("R8 pending line withheld", msg_grant, 1'b0);
    msg_addr = 32'h50; #1;
    check("R8 free line granted", msg_grant, 1'b1);
    msg_valid = 1'b0;

    // barrier with a load in the same cycle
    @(negedge clk);
    rbar = 1'b1; ld_addr = 32'h10; #1;
    check("R5 same-cycle load held", ld_ready, 1'b0);
    @(negedge clk);
    rbar = 1'b0;
    // a line arriving after the barrier
    inv_valid = 1'b1; inv_addr = 32'h13; #1;
    check("R4 stall after barrier", ld_ready, 1'b0);
    if (inv_ack) exp_q.push_back(32'h13);
    @(negedge clk);
    inv_valid = 1'b0;
    tag_ready = 1'b1; #1;
    check("R4 three tagged left", ld_ready, 1'b0);
    @(negedge clk); #1;
    check("R4 two tagged left", ld_ready, 1'b0);
    @(negedge clk); #1;
    check("R4 last tagged left, no stale hit", ld_ready, 1'b0);
    @(negedge clk);
    tag_ready = 1'b0; ld_addr = 32'h13; #1;
    check("R6 late entry does not stall", ld_ready, 1'b1);
    check("R6 late entry still pending", tag_inv_valid, 1'b1);
    check("R7 late entry forces miss", ld_force_miss, 1'b1);
    ld_addr = 32'h10; #1;
    check("R4 applied line not pending", ld_force_miss, 1'b0);
    ld_valid = 1'b0;
    @(negedge clk);
    tag_ready = 1'b1;
    @(negedge clk);
    tag_ready = 1'b0; #1;
    check("R3 drained", tag_inv_valid, 1'b0);

    // barrier on empty queue
    @(negedge clk);
    rbar = 1'b1; ld_valid = 1'b1; #1;
    check("R5 empty barrier no stall", ld_ready, 1'b1);
    @(negedge clk);
    rbar = 1'b0; ld_valid = 1'b0; #1;
    check("R5 empty barrier leaves no tag", ld_ready, 1'b1);

    // fill all eight slots
    for (int k = 0; k < 8; k++) push_inv(32'h20 + k);
    @(negedge clk);
    inv_valid = 1'b1; inv_addr = 32'h40; #1;
    check("R2 full not acked", inv_ack, 1'b0);
    tag_ready = 1'b1;
    @(negedge clk);
    tag_ready = 1'b0; #1;
    check("R2 ack after space", inv_ack, 1'b1);
    exp_q.push_back(32'h40);
    @(negedge clk);
    inv_valid = 1'b0;
    tag_ready = 1'b1;
    repeat (10) @(negedge clk);
    tag_ready = 1'b0; #1;
    check("R3 all applied", tag_inv_valid, 1'b0);
    check("R1 scoreboard empty", 32'(exp_q.size()), 32'd0);
    finish_run();
  end
endmodule